// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block drives a four-wire serial flash port from two word-addressed buffers. Software writes the outgoing byte stream into a transmit buffer. The first word always carries the command opcode and any address bytes, and a page-program payload follows from the second word onward. Software then writes a length code to the control register. That write starts one chip-select framed transfer of `(code+1)*8` serial clocks. Each clock shifts one bit out and captures one bit in, and the captured bytes land in a receive buffer that software reads back afterwards.

The serial clock runs at a quarter of the system clock. Outgoing data is launched on the falling serial edge and incoming data is taken on the rising serial edge. Bits travel most significant first. Each 32-bit buffer word holds four bytes, with the first byte on the wire in bits 31:24. Software polls the busy flag in the control register to learn when the receive buffer is complete.

Register map, word addresses (default depth 128): control at 0x000; transmit buffer at 0x100–0x17F; receive buffer at 0x180–0x1FF. Read data is registered and appears one cycle after the address.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select (active low) is high, the serial clock is low, and the control register reads 0.
- R2: Every transmit-buffer location reads back the last value written to it.
- R3: The receive buffer is read-only: a bus write to a receive-buffer address leaves the value read there unchanged.
- R4: A write to control address 0 while idle starts a transfer whose length is taken from data bits 8:0 (code n). The transfer gives exactly 8*(n+1) serial clock pulses.
- R5: Control bit 0 reads 1 while a transfer is in progress and 0 once it has ended. All other control bits read 0.
- R6: Serial bit i of the output stream is bit 31-(i mod 32) of transmit word i/32. The command word is therefore sent first, MSB first, and the payload follows from word 1.
- R7: While chip select is low, the serial clock stays low for two system clocks and then high for two. Data out changes only when the serial clock falls, or when a transfer starts.
- R8: Received byte k is taken from data in at the rising serial edges and is stored in receive word k/4, bits 31-8*(k mod 4) down to 24-8*(k mod 4).
- R9: Chip select goes low at the start edge and rises one system clock after the last serial clock period ends. It is therefore low for 32*(n+1)+1 system clocks.
- R10: Control writes made while a transfer is in progress are ignored. The running transfer keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 9 | Word address for bus read and write |
| regWrEn | input | 1 | Bus write strobe |
| regWrData | input | 32 | Bus write data |
| regRdData | output | 32 | Registered read data for the previous cycle's address |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSclk | output | 1 | Serial clock, system clock / 4 |
| flashMosi | output | 1 | Serial data to the flash |
| flashMiso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is a control write that arrives in the middle of a transfer. Only that case can show whether the length register is protected. The bench starts a short transfer and, while chip select is still low, issues a second start with a much larger code. It then counts serial pulses and chip-select low cycles at the pins. A flash model replays a known byte pattern on data in, indexed by the rising serial edges. Byte placement and partial final words can then be checked word by word through the receive-buffer window.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int WORD_LOG = $clog2(WORD_W);
  localparam int BYTE_LOG = $clog2(BYTE_W);
  localparam int LANES    = WORD_W / BYTE_W;
  localparam int LANE_LOG = $clog2(LANES);
  localparam int CLK_DIV  = 4;
  localparam int PH_W     = $clog2(CLK_DIV);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL
  } eng_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // start edge: present first outgoing bit
    logic advance;  // falling serial edge: present next outgoing bit
    logic sample;   // rising serial edge: capture incoming bit
  } shift_strb_t;
endpackage

// File: rtl/flash_eng_ctrl.sv
module flash_eng_ctrl
  import flash_eng_pkg::*;
#(
  parameter int LEN_W = 9,
  localparam int BIT_W = LEN_W + BYTE_LOG
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] startLen,
  output shift_strb_t      strb,
  output logic [BIT_W-1:0] bitIdx,
  output logic             busy,
  output logic             csN,
  output logic             sclk
);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(CLK_DIV/2 - 1);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(CLK_DIV - 1);

  eng_state_e       state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] lastIdx;
  logic             inShift;
  logic             atLastBit;

  assign inShift   = (state == ST_SHIFT);
  assign atLastBit = (bitIdx == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          phase <= '0;
          if (startReq) begin
            state   <= ST_SHIFT;
            bitIdx  <= '0;
            lastIdx <= {startLen, {BYTE_LOG{1'b1}}};
          end
        end
        ST_SHIFT: begin
          phase <= phase + PH_W'(1);
          if (phase == PH_LAST) begin
            if (atLastBit) state  <= ST_TAIL;
            else           bitIdx <= bitIdx + BIT_W'(1);
          end
        end
        ST_TAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && startReq;
    strb.sample  = inShift && (phase == PH_SAMPLE);
    strb.advance = inShift && (phase == PH_LAST) && !atLastBit;
  end

  assign busy = (state != ST_IDLE);
  assign csN  = (state == ST_IDLE);
  assign sclk = inShift && (phase > PH_SAMPLE);
endmodule

// File: rtl/flash_eng_dpath.sv
module flash_eng_dpath
  import flash_eng_pkg::*;
#(
  parameter int IDX_W = 7,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int ADDR_W = IDX_W + 2,
  localparam int BIT_W  = IDX_W + WORD_LOG
) (
  input  logic              clk,
  input  logic              rstN,
  input  shift_strb_t       strb,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic              busy,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic              mosi,
  input  logic              miso
);
  logic [WORD_W-1:0] txBuf [DEPTH];
  logic [WORD_W-1:0] rxBuf [DEPTH];

  logic              bufZone, rxZone;
  logic [IDX_W-1:0]  bufIdx;
  logic [BIT_W-1:0]  nextIdx;
  logic [BYTE_W-2:0] rxShift;
  logic              byteDone;
  logic [IDX_W-1:0]  rxWord;
  logic [LANE_LOG-1:0] rxLane;

  assign bufZone  = busAddr[ADDR_W-1];
  assign rxZone   = busAddr[ADDR_W-2];
  assign bufIdx   = busAddr[IDX_W-1:0];
  assign nextIdx  = strb.load ? '0 : bitIdx + BIT_W'(1);
  assign byteDone = strb.sample && (&bitIdx[BYTE_LOG-1:0]);
  assign rxWord   = bitIdx[BIT_W-1:WORD_LOG];
  assign rxLane   = bitIdx[WORD_LOG-1:BYTE_LOG];

  // transmit buffer: bus writes only
  always_ff @(posedge clk) begin
    if (busWrEn && bufZone && !rxZone) txBuf[bufIdx] <= busWrData;
  end

  // receive buffer: filled one byte lane at a time from the serial side
  always_ff @(posedge clk) begin
    if (byteDone) begin
      for (int l = 0; l < LANES; l++) begin
        if (rxLane == LANE_LOG'(l))
          rxBuf[rxWord][(LANES-1-l)*BYTE_W +: BYTE_W] <= {rxShift, miso};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosi    <= 1'b0;
      rxShift <= '0;
    end else begin
      if (strb.load || strb.advance)
        mosi <= txBuf[nextIdx[BIT_W-1:WORD_LOG]][~nextIdx[WORD_LOG-1:0]];
      if (strb.sample)
        rxShift <= {rxShift[BYTE_W-3:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (!bufZone) begin
      busRdData <= (busAddr == '0) ? {{(WORD_W-1){1'b0}}, busy} : '0;
    end else begin
      busRdData <= rxZone ? rxBuf[bufIdx] : txBuf[bufIdx];
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_eng_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  localparam int IDX_W  = $clog2(BUF_DEPTH),
  localparam int ADDR_W = IDX_W + 2,
  localparam int LEN_W  = IDX_W + LANE_LOG,
  localparam int BIT_W  = LEN_W + BYTE_LOG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              flashCsN,
  output logic              flashSclk,
  output logic              flashMosi,
  input  logic              flashMiso
);
  shift_strb_t      strb;
  logic [BIT_W-1:0] bitIdx;
  logic             busy;
  logic             startReq;

  assign startReq = regWrEn && (regAddr == '0);

  flash_eng_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .startLen (regWrData[LEN_W-1:0]),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .busy     (busy),
    .csN      (flashCsN),
    .sclk     (flashSclk)
  );

  flash_eng_dpath #(.IDX_W(IDX_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .busy      (busy),
    .busWrEn   (regWrEn),
    .busAddr   (regAddr),
    .busWrData (regWrData),
    .busRdData (regRdData),
    .mosi      (flashMosi),
    .miso      (flashMiso)
  );
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [LEN_W-1:0]  wrLen,
  input logic              flashCsN,
  input logic              flashSclk,
  input logic              flashMosi
);
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W+3:0] riseCnt;
  logic             sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ    <= '0;
      riseCnt <= '0;
      sclkQ   <= 1'b0;
    end else begin
      sclkQ <= flashSclk;
      if (regWrEn && regAddr == '0 && flashCsN) begin
        lenQ    <= wrLen;
        riseCnt <= '0;
      end else if (flashSclk && !sclkQ) begin
        riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  // R4 / R10: pulse count fixed by the length accepted at start
  a_r4_pulse_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |-> riseCnt == ({4'b0, lenQ} + 1'b1) * 8);

  // R9: chip select released one clock after the last high phase
  a_r9_cs_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |-> (!$past(flashSclk) && $past(flashSclk, 2)));

  // R7: high phase is two system clocks
  a_r7_sclk_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashSclk) |=> flashSclk ##1 !flashSclk);

  // R7: low phase inside a transfer is at least two system clocks
  a_r7_sclk_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashSclk) && !flashCsN) |=> !flashSclk);

  // R7: data out only moves on a falling serial edge
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!flashCsN && !$past(flashCsN) && !$fell(flashSclk)) |-> $stable(flashMosi));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .wrLen     (regWrData[LEN_W-1:0]),
  .flashCsN  (flashCsN),
  .flashSclk (flashSclk),
  .flashMosi (flashMosi)
);

// File: tb/flash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb_top;
  localparam int TX_BASE = 'h100;
  localparam int RX_BASE = 'h180;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        flashCsN, flashSclk, flashMosi, flashMiso;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  flash_cmd_engine dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .flashCsN(flashCsN),
    .flashSclk(flashSclk), .flashMosi(flashMosi), .flashMiso(flashMiso)
  );

  // flash model: records data out, replays a pattern on data in
  int           sclkRises = 0;
  int           csLow = 0;
  logic [127:0] capBits = '0;
  logic [127:0] misoPat = '0;
  int           startIdx = 0;
  logic [6:0]   misoOff;

  always @(posedge flashSclk) begin
    capBits[sclkRises[6:0]] <= flashMosi;
    sclkRises <= sclkRises + 1;
  end
  always @(negedge clk) if (!flashCsN) csLow <= csLow + 1;

  assign misoOff   = sclkRises[6:0] - startIdx[6:0];
  assign flashMiso = misoPat[7'd127 - misoOff];

  typedef struct packed {
    logic [8:0]  len;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [63:0] pat;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{9'd0, 32'h9F00_0000, 32'h0000_0000, 64'hA55A_0000_0000_0000},
    '{9'd3, 32'h0312_3456, 32'hFFFF_FFFF, 64'h00C3_3C81_0000_0000},
    '{9'd4, 32'h0200_1000, 32'hDEAD_BEEF, 64'h1122_3344_5566_7788},
    '{9'd7, 32'h0B00_0080, 32'h8001_7FFE, 64'hF00F_E11E_D22D_C33C}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = 9'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 9'(a); regWrEn = 1'b0;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic waitIdle();
    while (!flashCsN) @(negedge clk);
  endtask

  // run one transfer of code n with words tx[0..3] loaded, check R4 R6 R8 R9
  task automatic runXfer(input int n, input logic [31:0] tx [4], input logic [127:0] pat);
    int rise0, low0, nBits;
    logic [127:0] expBits, actBits;
    logic [31:0] rd, expW, mask;
    nBits = 8 * (n + 1);
    misoPat = pat;
    startIdx = sclkRises;
    rise0 = sclkRises;
    low0 = csLow;
    busWrite(0, 32'(n));
    waitIdle();
    @(negedge clk);
    chk("R4 pulse count", 128'(sclkRises - rise0), 128'(nBits));
    chk("R9 cs low cycles", 128'(csLow - low0), 128'(4 * nBits + 1));
    expBits = '0; actBits = '0;
    for (int i = 0; i < nBits; i++) begin
      expBits[i] = tx[i / 32][31 - (i % 32)];
      actBits[i] = capBits[(rise0 + i) % 128];
    end
    chk("R6 bit stream", actBits, expBits);
    for (int w = 0; w < (n + 4) / 4; w++) begin
      busRead(RX_BASE + w, rd);
      expW = '0; mask = '0;
      for (int l = 0; l < 4; l++) begin
        if (4 * w + l <= n) begin
          expW[31 - 8*l -: 8] = pat[127 - 8*(4*w + l) -: 8];
          mask[31 - 8*l -: 8] = 8'hFF;
        end
      end
      chk("R8 rx word", 128'(rd & mask), 128'(expW));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt + 1, failCnt + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, rd2;
    logic [31:0] tx [4];
    logic [7:0]  pulse;
    int rise0, low0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 cs idle", 128'(flashCsN), 128'(1));
    chk("R1 sclk idle", 128'(flashSclk), 128'(0));
    busRead(0, rd);
    chk("R1 control reads zero", 128'(rd), 128'(0));

    // R2 transmit buffer readback
    busWrite(TX_BASE + 5, 32'hCAFE_0005);
    busWrite(TX_BASE + 127, 32'h1357_9BDF);
    busRead(TX_BASE + 5, rd);
    chk("R2 tx word 5", 128'(rd), 128'(32'hCAFE_0005));
    busRead(TX_BASE + 127, rd);
    chk("R2 tx word 127", 128'(rd), 128'(32'h1357_9BDF));

    // table-driven transfers
    foreach (VEC[v]) begin
      tx[0] = VEC[v].w0; tx[1] = VEC[v].w1; tx[2] = '0; tx[3] = '0;
      busWrite(TX_BASE + 0, tx[0]);
      busWrite(TX_BASE + 1, tx[1]);
      runXfer(int'(VEC[v].len), tx, {VEC[v].pat, 64'h0});
    end

    // long transfer over four words, command word then payload
    tx[0] = 32'h0200_0100; tx[1] = 32'h0123_4567; tx[2] = 32'h89AB_CDEF; tx[3] = 32'h5A5A_A5A5;
    for (int i = 0; i < 4; i++) busWrite(TX_BASE + i, tx[i]);
    runXfer(15, tx, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);

    // R3 receive buffer is read-only
    busRead(RX_BASE + 1, rd);
    busWrite(RX_BASE + 1, ~rd);
    busRead(RX_BASE + 1, rd2);
    chk("R3 rx word unchanged", 128'(rd2), 128'(rd));

    // R7 serial clock shape right after start
    busWrite(0, 32'd0);
    pulse = '0;
    for (int i = 0; i < 8; i++) begin
      pulse = {pulse[6:0], flashSclk};
      @(negedge clk);
    end
    chk("R7 sclk 2 low 2 high", 128'(pulse), 128'(8'b0011_0011));
    waitIdle();

    // R5 busy flag during and after
    busWrite(0, 32'd1);
    busRead(0, rd);
    chk("R5 busy during transfer", 128'(rd), 128'(1));
    waitIdle();
    busRead(0, rd);
    chk("R5 idle after transfer", 128'(rd), 128'(0));

    // R10 start while busy ignored
    rise0 = sclkRises; low0 = csLow;
    busWrite(0, 32'd3);
    repeat (10) @(negedge clk);
    busWrite(0, 32'd100);
    waitIdle();
    @(negedge clk);
    chk("R10 pulse count keeps first length", 128'(sclkRises - rise0), 128'(32));
    chk("R10 cs low keeps first length", 128'(csLow - low0), 128'(129));
    chk("R10 idle afterwards", 128'(flashCsN), 128'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule